// File: doc/BRIEF.md
# Dual Clock Activity Monitor with Failover

This block sits between two clock sources, an on-chip oscillator and an externally supplied clock, and the clock tree of the chip. Through a glitch-free switch it selects one of them as the system clock and the timebase clock. When software arms it, the block also checks that each source keeps toggling. Each source runs a small divider, the activity beacon. That beacon is sampled in the domain of the other source, and if no beacon edge arrives within a bounded number of cycles, the source is declared inactive.

A dead source is switched out by the block itself, with no help from software. If the dead source was driving the outputs, the select bit moves to the surviving source. In either case a sticky failure flag is raised, and an interrupt is requested when software has enabled it. Software reads the select bit to learn which source failed. It clears the flag with a read that sees it set, followed by a write of zero. A configuration pin tells the block whether the external clock is slow, and this pin widens the detection window for the external source.

All register accesses are synchronous to a bus clock. The control word is four bits wide: bit 0 arms the monitor, bit 1 enables the interrupt, bit 2 is the failure flag, and bit 3 is the source select (0 selects the internal source, 1 the external).

Top module: `clk_failover_mon`

## Requirements
- R1: After asynchronous reset the control word reads 0000, `irq` is low, and both clock outputs follow the internal source.
- R2: A write with bit 0 set arms the monitor only when `int_stable` and `ext_stable` are both high in that cycle. At any other time the arming request is ignored.
- R3: Once armed, the monitor stays armed when either stability input falls. Only a write with bit 0 clear disarms it.
- R4: When the monitor is armed and the selected source stops, bit 3 moves to the other source, bit 2 is set, and both clock outputs then follow the surviving source.
- R5: When the monitor is armed and the unselected source stops, bit 2 is set and bit 3 keeps its value.
- R6: A write with bit 2 clear clears the flag only if an earlier read returned the flag as 1. A write that disarms the monitor discards that earlier read. A write of 0 with no such read leaves the flag set.
- R7: Writing 1 to bit 2 never changes the flag.
- R8: `irq` is high exactly while the flag and bit 1 are both set.
- R9: With `ext_slow` low, the external source is declared dead after 24 internal-clock cycles without a beacon edge. With `ext_slow` high, the window is 96 cycles. The internal source is declared dead after 8 external-clock cycles without a beacon edge.
- R10: A write to bit 3 takes effect only while the monitor is disarmed. While the monitor is armed, such a write is ignored.
- R11: No high pulse on either clock output is shorter than the shorter half-period of the two sources.
- R12: `sys_clk` and `tb_clk` always carry the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Register interface clock |
| int_clk | input | 1 | Internal oscillator clock |
| ext_clk | input | 1 | External clock |
| int_stable | input | 1 | Internal source reported stable |
| ext_stable | input | 1 | External source reported stable |
| ext_slow | input | 1 | External clock is slow; selects the long detection window |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read strobe for the control word |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Control word: bit3 select, bit2 flag, bit1 irq enable, bit0 arm |
| irq | output | 1 | Failure interrupt request |
| sys_clk | output | 1 | System clock from the selected source |
| tb_clk | output | 1 | Timebase clock from the selected source |

## Verification
Suppose a detector counter or a dead indication is stuck. Once the detection window has elapsed, the flag and the select bit read back the wrong value, and the edge counts on the clock outputs come from the wrong source. Suppose instead that the read-armed state is wrong. Then the write after the read gives it away: the flag clears when it should stay set, or stays set when it should clear. A broken switch sequence shows up as a short high pulse on the outputs, and that pulse appears within a couple of source cycles of the change to the select bit.

// File: rtl/clk_failover_pkg.sv
`timescale 1ns/1ps
package clk_failover_pkg;

  localparam int B_ARM  = 0;
  localparam int B_IRQE = 1;
  localparam int B_FLAG = 2;
  localparam int B_SEL  = 3;
  localparam int REG_W  = 4;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // detection window for the external source, in internal-clock cycles
  function automatic int ext_window(input logic slow, input int fast_w, input int slow_w);
    return slow ? slow_w : fast_w;
  endfunction

  // next arm bit: setting is gated by both stability inputs, clearing is free
  function automatic logic next_arm(input logic cur, input logic wr, input logic req,
                                    input logic int_ok, input logic ext_ok);
    if (!wr)  return cur;
    if (!req) return 1'b0;
    return cur | (int_ok & ext_ok);
  endfunction

endpackage

// File: rtl/clk_activity_det.sv
`timescale 1ns/1ps
module clk_activity_det #(
  parameter int BEACON_BITS = 3,
  parameter int CW          = 7
) (
  input  logic          rst_n,
  input  logic          src_clk,
  input  logic          chk_clk,
  input  logic          arm,
  input  logic [CW-1:0] limit,
  output logic          dead
);

  logic [BEACON_BITS-1:0] div_q;
  logic [2:0]             bcn_s;
  logic [1:0]             arm_s;
  logic [CW-1:0]          cnt;
  logic                   bcn_edge;

  // beacon: divided source clock, slow enough to be sampled by the other source
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) begin
      bcn_s <= '0;
      arm_s <= '0;
    end else begin
      bcn_s <= {bcn_s[1:0], div_q[BEACON_BITS-1]};
      arm_s <= {arm_s[0], arm};
    end
  end

  assign bcn_edge = bcn_s[2] ^ bcn_s[1];

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dead <= 1'b0;
    end else if (!arm_s[1]) begin
      cnt  <= '0;
      dead <= 1'b0;
    end else if (bcn_edge) begin
      cnt  <= '0;
    end else if (cnt >= limit - 1'b1) begin
      dead <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R4
  dead_hold_chk: assert property (@(posedge chk_clk) disable iff (!rst_n)
    dead && arm_s[1] |=> dead);

endmodule

// File: rtl/clk_glitchfree_mux.sv
`timescale 1ns/1ps
module clk_glitchfree_mux (
  input  logic rst_n,
  input  logic int_clk,
  input  logic ext_clk,
  input  logic sel_ext,
  input  logic kill_int,
  input  logic kill_ext,
  output logic out_clk,
  output logic en_int,
  output logic en_ext
);

  logic [1:0] src_clk;
  logic [1:0] want;
  logic [1:0] kill;
  logic [1:0] en;

  assign src_clk = {ext_clk, int_clk};
  assign want    = {sel_ext, ~sel_ext};
  assign kill    = {kill_ext, kill_int};

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic stg1, stg2, clr_n;
    assign clr_n = rst_n & ~kill[g];
    // enable changes only while this source is low; a dead source is cut asynchronously
    always_ff @(negedge src_clk[g] or negedge clr_n) begin
      if (!clr_n) begin
        stg1 <= 1'b0;
        stg2 <= 1'b0;
      end else begin
        stg1 <= want[g] & ~en[1-g];
        stg2 <= stg1;
      end
    end
    assign en[g] = stg2;
  end

  assign en_int  = en[0];
  assign en_ext  = en[1];
  assign out_clk = (int_clk & en_int) | (ext_clk & en_ext);

  // R11
  always_comb begin
    if (rst_n) mux_excl_chk: assert ($onehot0({en_int, en_ext}));
  end

endmodule

// File: rtl/clk_failover_ctrl.sv
`timescale 1ns/1ps
module clk_failover_ctrl
  import clk_failover_pkg::*;
(
  input  logic             rst_n,
  input  logic             bus_clk,
  input  logic             int_stable,
  input  logic             ext_stable,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             dead_int_a,
  input  logic             dead_ext_a,
  output logic             mon_en,
  output logic             sel_ext,
  output logic             fail_evt,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);

  logic [1:0] si, se;
  logic d_int_s, d_ext_s;
  logic seen_int, seen_ext;
  logic irq_en, flag, rd_armed;
  logic evt_int, evt_ext, disarm_wr, clr_ok;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      si <= '0;
      se <= '0;
    end else begin
      si <= {si[0], dead_int_a};
      se <= {se[0], dead_ext_a};
    end
  end
  assign d_int_s = si[1];
  assign d_ext_s = se[1];

  assign evt_int   = mon_en & d_int_s & ~seen_int;
  assign evt_ext   = mon_en & d_ext_s & ~seen_ext;
  assign fail_evt  = evt_int | evt_ext;
  assign disarm_wr = reg_wr & ~reg_wdata[B_ARM] & mon_en;
  assign clr_ok    = reg_wr & ~reg_wdata[B_FLAG] & rd_armed;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en   <= 1'b0;
      irq_en   <= 1'b0;
      flag     <= 1'b0;
      rd_armed <= 1'b0;
      sel_ext  <= 1'b0;
      seen_int <= 1'b0;
      seen_ext <= 1'b0;
    end else begin
      mon_en <= next_arm(mon_en, reg_wr, reg_wdata[B_ARM], int_stable, ext_stable);
      if (reg_wr) irq_en <= reg_wdata[B_IRQE];

      seen_int <= mon_en & (seen_int | d_int_s);
      seen_ext <= mon_en & (seen_ext | d_ext_s);

      if (fail_evt)    flag <= 1'b1;
      else if (clr_ok) flag <= 1'b0;

      if (clr_ok || disarm_wr)  rd_armed <= 1'b0;
      else if (reg_rd && flag)  rd_armed <= 1'b1;

      if (mon_en && d_int_s && !d_ext_s)      sel_ext <= 1'b1;
      else if (mon_en && d_ext_s && !d_int_s) sel_ext <= 1'b0;
      else if (reg_wr && !mon_en)             sel_ext <= reg_wdata[B_SEL];
    end
  end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[B_ARM]  = mon_en;
    reg_rdata[B_IRQE] = irq_en;
    reg_rdata[B_FLAG] = flag;
    reg_rdata[B_SEL]  = sel_ext;
  end
  assign irq = flag & irq_en;

  // R2
  arm_gate_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(mon_en) |-> $past(int_stable && ext_stable));
  // R3
  arm_hold_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    mon_en && !(reg_wr && !reg_wdata[B_ARM]) |=> mon_en);
  // R7
  flag_w1_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    flag && reg_wr && reg_wdata[B_FLAG] |=> flag);
  // R6
  flag_clr_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $fell(flag) |-> $past(rd_armed && reg_wr && !reg_wdata[B_FLAG]));
  // R4
  failover_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    mon_en && !sel_ext && d_int_s && !d_ext_s |=> sel_ext && flag);
  // R10
  sel_lock_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    mon_en && !d_int_s && !d_ext_s |=> $stable(sel_ext));

endmodule

// File: rtl/clk_failover_mon.sv
`timescale 1ns/1ps
module clk_failover_mon
  import clk_failover_pkg::*;
#(
  parameter int INT_WIN      = 8,
  parameter int EXT_WIN_FAST = 24,
  parameter int EXT_WIN_SLOW = 96,
  parameter int BEACON_BITS  = 3
) (
  input  logic             rst_n,
  input  logic             bus_clk,
  input  logic             int_clk,
  input  logic             ext_clk,
  input  logic             int_stable,
  input  logic             ext_stable,
  input  logic             ext_slow,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             sys_clk,
  output logic             tb_clk
);

  localparam int MAX_WIN = max_of(INT_WIN, max_of(EXT_WIN_FAST, EXT_WIN_SLOW));
  localparam int CW      = $clog2(MAX_WIN + 1);

  logic          mon_en, sel_ext, fail_evt;
  logic          dead_int, dead_ext;
  logic          en_int, en_ext, mux_clk;
  logic [CW-1:0] lim_int, lim_ext;

  assign lim_int = CW'(INT_WIN);
  assign lim_ext = CW'(ext_window(ext_slow, EXT_WIN_FAST, EXT_WIN_SLOW));

  // internal source watched from the external domain
  clk_activity_det #(.BEACON_BITS(BEACON_BITS), .CW(CW)) u_det_int (
    .rst_n(rst_n), .src_clk(int_clk), .chk_clk(ext_clk),
    .arm(mon_en), .limit(lim_int), .dead(dead_int));

  // external source watched from the internal domain
  clk_activity_det #(.BEACON_BITS(BEACON_BITS), .CW(CW)) u_det_ext (
    .rst_n(rst_n), .src_clk(ext_clk), .chk_clk(int_clk),
    .arm(mon_en), .limit(lim_ext), .dead(dead_ext));

  clk_failover_ctrl u_ctrl (
    .rst_n(rst_n), .bus_clk(bus_clk),
    .int_stable(int_stable), .ext_stable(ext_stable),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .dead_int_a(dead_int), .dead_ext_a(dead_ext),
    .mon_en(mon_en), .sel_ext(sel_ext), .fail_evt(fail_evt),
    .reg_rdata(reg_rdata), .irq(irq));

  clk_glitchfree_mux u_mux (
    .rst_n(rst_n), .int_clk(int_clk), .ext_clk(ext_clk),
    .sel_ext(sel_ext), .kill_int(dead_int), .kill_ext(dead_ext),
    .out_clk(mux_clk), .en_int(en_int), .en_ext(en_ext));

  assign sys_clk = mux_clk;
  assign tb_clk  = mux_clk;

  // R5
  flag_on_fail_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    fail_evt |=> reg_rdata[B_FLAG]);
  // R12
  always_comb begin
    out_match_chk: assert (sys_clk == tb_clk);
  end

endmodule

// File: tb/clk_failover_mon_tb.sv
`timescale 1ns/1ps
module clk_failover_mon_tb;

  logic       rst_n = 1'b0;
  logic       bus_clk = 1'b0;
  logic       int_clk = 1'b0;
  logic       ext_clk = 1'b0;
  logic       int_stable = 1'b1, ext_stable = 1'b1, ext_slow = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       irq, sys_clk, tb_clk;

  bit  int_run = 1'b1, ext_run = 1'b1;
  int  ext_half = 24;
  int  tests = 0, fails = 0;
  int  sys_cnt = 0, tb_cnt = 0;
  bit  done = 1'b0;
  realtime t_rise = 0, min_hi = 1.0e9;

  clk_failover_mon u_dut (
    .rst_n(rst_n), .bus_clk(bus_clk), .int_clk(int_clk), .ext_clk(ext_clk),
    .int_stable(int_stable), .ext_stable(ext_stable), .ext_slow(ext_slow),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .sys_clk(sys_clk), .tb_clk(tb_clk));

  always #4 bus_clk = ~bus_clk;
  initial forever begin #10; if (int_run) int_clk = ~int_clk; end
  initial forever begin #(ext_half); if (ext_run) ext_clk = ~ext_clk; end

  always @(posedge sys_clk) begin sys_cnt++; t_rise = $realtime; end
  always @(posedge tb_clk) tb_cnt++;
  always @(negedge sys_clk) if (t_rise > 0 && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge bus_clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge bus_clk); reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [3:0] d);
    @(negedge bus_clk); reg_rd = 1'b1; #1; d = reg_rdata;
    @(negedge bus_clk); reg_rd = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] exp);
    logic [3:0] v;
    rd(v);
    check(req, int'(v), int'(exp));
  endtask

  // over 960 ns: internal source (20 ns) gives 48 rising edges, external (48 ns) gives 20
  task automatic expect_follow(input string req, input bit from_ext);
    int s0, t0, ns, nt, e;
    #200;
    s0 = sys_cnt; t0 = tb_cnt;
    #960;
    ns = sys_cnt - s0; nt = tb_cnt - t0;
    e = from_ext ? 20 : 48;
    check(req, (ns >= e - 2 && ns <= e + 2) ? e : ns, e);
    check("R12", nt, ns);
  endtask

  task automatic t_reset;
    expect_reg("R1 reset word", 4'b0000);
    check("R1 irq", int'(irq), 0);
    expect_follow("R1 internal source", 1'b0);
  endtask

  task automatic t_arm_rules;
    @(negedge bus_clk); ext_stable = 1'b0;
    wr(4'b0001);
    expect_reg("R2 arm ignored when unstable", 4'b0000);
    @(negedge bus_clk); ext_stable = 1'b1;
    wr(4'b0001);
    expect_reg("R2 arm accepted", 4'b0001);
    @(negedge bus_clk); int_stable = 1'b0;
    #100;
    expect_reg("R3 stays armed", 4'b0001);
    wr(4'b1001);
    expect_reg("R10 select ignored while armed", 4'b0001);
    wr(4'b0000);
    expect_reg("R3 disarm by write", 4'b0000);
    wr(4'b1000);
    expect_reg("R10 select while disarmed", 4'b1000);
    expect_follow("R10 external source", 1'b1);
    wr(4'b0000);
    expect_follow("R10 back to internal", 1'b0);
    @(negedge bus_clk); int_stable = 1'b1;
  endtask

  task automatic t_fail_sel_int;
    wr(4'b0011);
    int_run = 1'b0;
    #2000;
    wr(4'b0111);
    wr(4'b0011);
    expect_reg("R4 failover to external", 4'b1111);
    check("R8 irq on flag", int'(irq), 1);
    wr(4'b0111);
    expect_reg("R7 write one keeps flag", 4'b1111);
    expect_follow("R4 outputs follow external", 1'b1);
    wr(4'b0011);
    expect_reg("R6 clear after read", 4'b1011);
    check("R8 irq drops", int'(irq), 0);
    wr(4'b1010);
    #200;
    int_run = 1'b1;
    #500;
  endtask

  task automatic t_fail_unsel;
    wr(4'b1001);
    int_run = 1'b0;
    #2000;
    expect_reg("R5 unselected failure", 4'b1101);
    check("R8 irq gated by enable", int'(irq), 0);
    wr(4'b1100);
    wr(4'b1000);
    expect_reg("R6 disarm discards read", 4'b1100);
    wr(4'b1000);
    expect_reg("R6 clear after new read", 4'b1000);
    int_run = 1'b1;
    #500;
  endtask

  task automatic t_fail_sel_ext;
    wr(4'b1011);
    ext_run = 1'b0;
    #2000;
    expect_reg("R4 failover to internal", 4'b0111);
    check("R8 irq", int'(irq), 1);
    expect_follow("R4 outputs follow internal", 1'b0);
    wr(4'b0011);
    expect_reg("R6 clear", 4'b0011);
    wr(4'b0000);
    #200;
    ext_run = 1'b1;
    #500;
  endtask

  task automatic t_slow_window;
    ext_half = 100;
    ext_slow = 1'b0;
    #1000;
    wr(4'b0001);
    #3000;
    expect_reg("R9 fast window flags slow clock", 4'b0101);
    wr(4'b0001);
    expect_reg("R9 clear", 4'b0001);
    wr(4'b0000);
    ext_slow = 1'b1;
    #500;
    wr(4'b0001);
    #4000;
    expect_reg("R9 slow window tolerates slow clock", 4'b0001);
    wr(4'b0000);
    ext_half = 24;
    #500;
  endtask

  initial begin
    #100;
    @(negedge bus_clk); rst_n = 1'b1;
    #200;
    t_reset();
    t_arm_rules();
    t_fail_sel_int();
    t_fail_unsel();
    t_fail_sel_ext();
    t_slow_window();
    check("R11 shortest high pulse >= 10ns", (min_hi >= 9.9) ? 1 : 0, 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule